// File: doc/BRIEF.md
# Instruction-Aware Unit Clock Controller

This block sits beside a five-stage RV32I pipeline (fetch, decode, execute, memory, write back) and decides, cycle by cycle, which units need a clock edge. It reads the opcode and funct fields of the instructions now in execute, memory and write back. For each of these it sorts the instruction into one of five supported classes: register-register arithmetic, immediate arithmetic, load, store and branch. From that class it decides whether the ALU, the data memory or the register-file write port does any work. It also takes a valid bit per stage, a per-stage flush, a per-pipeline-register hold and a core idle flag.

Each request is captured on the falling edge of the free-running clock and ANDed with that clock. A request raised during one cycle therefore governs the next rising edge only, and a gated clock can only change state while the free clock is low. The registered enables are brought out next to the gated clocks, so a datapath can use either. There is no stream data through the block, so every pin is a plain level-sensitive control signal.

Top module: `unit_clk_ctrl`

## Requirements
- R1: Instruction classes are recognised from opcode bits [6:0]: 0110011 register-register, 0010011 immediate arithmetic, 0000011 load, 0100011 store, 1100011 branch; funct3 is bits [14:12], funct7 bits [31:25], rd bits [11:7].
- R2: `alu_en_o` is high only when the execute instruction is valid and is register-register, immediate arithmetic or branch.
- R3: `dmem_en_o` is high only when the memory-stage instruction is a valid load or store.
- R4: `rfw_en_o` is high only when the write-back instruction is a valid register-register, immediate arithmetic or load with rd not zero; stores, branches and rd = 0 leave it low.
- R5: An unknown opcode, or an illegal funct combination, enables no unit. Illegal combinations are: funct7 other than 0000000 or 0100000 in register-register; 0100000 with funct3 other than 000 or 101; slli with funct7 not zero; srli/srai with funct7 other than 0000000 or 0100000; load funct3 011, 110 or 111; store funct3 above 010; branch funct3 010 or 011.
- R6: `preg_en_o[k]` (k = 0 for fetch/decode, up to the register after memory) is high exactly when `idle_i` is low and `hold_i[k]` is low.
- R7: A hold on the register after execute (`hold_i[NPR-2]`) blocks the ALU enable, and a hold on the register after memory (`hold_i[NPR-1]`) blocks the data-memory enable.
- R8: `flush_i[0]`, `[1]` and `[2]` turn the execute, memory and write-back instruction into a bubble, so that the unit belonging to that stage is not enabled.
- R9: Enables are captured on the falling clock edge: the request present during a cycle appears after that cycle's falling edge and is unchanged across the rising edge that follows.
- R10: Each gated clock is high only while the free clock is high and its registered enable is set; it is never high while the clock is low.
- R11: An asynchronous active-low reset clears every enable and holds every gated clock low. A stage whose valid bit is low enables nothing.
- R12: `idle_i` forces every enable low, for both units and pipeline registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ex_op_i | input | 7 | Execute-stage opcode |
| ex_f3_i | input | 3 | Execute-stage funct3 |
| ex_f7_i | input | 7 | Execute-stage funct7 |
| ex_valid_i | input | 1 | Execute stage holds an instruction |
| mem_op_i | input | 7 | Memory-stage opcode |
| mem_f3_i | input | 3 | Memory-stage funct3 |
| mem_valid_i | input | 1 | Memory stage holds an instruction |
| wb_op_i | input | 7 | Write-back opcode |
| wb_f3_i | input | 3 | Write-back funct3 |
| wb_f7_i | input | 7 | Write-back funct7 |
| wb_rd_i | input | 5 | Write-back destination register |
| wb_valid_i | input | 1 | Write-back stage holds an instruction |
| flush_i | input | 3 | Bubble request: bit 0 execute, 1 memory, 2 write back |
| hold_i | input | NPR | Per pipeline register hold (stall) |
| idle_i | input | 1 | Core idle, everything off |
| alu_en_o | output | 1 | Registered ALU enable |
| dmem_en_o | output | 1 | Registered data-memory enable |
| rfw_en_o | output | 1 | Registered register-file write enable |
| preg_en_o | output | NPR | Registered pipeline-register enables |
| alu_gclk_o | output | 1 | Gated ALU clock |
| dmem_gclk_o | output | 1 | Gated data-memory clock |
| rfw_gclk_o | output | 1 | Gated register-file write clock |
| preg_gclk_o | output | NPR | Gated pipeline-register clocks |

## Verification
The bench walks instruction mixes in which every stage carries a different class, so a decoder wired to the wrong stage turns on the wrong unit. It covers encodings that sit next to legal ones: a multiply, sll with bit 30 set, a 64-bit load, a wide store, reserved branch conditions and LUI. A decoder that looks only at the opcode would enable units for these. It checks the enables just after the rising edge, before the next falling edge: a design that captured on the rising edge, or gated with a plain AND of the raw request, would show the new value too early and would clip or glitch the clock. Flush, hold, idle, rd = 0, a low valid bit and an asynchronous reset in mid-run are each driven on their own, so a mask applied to the wrong unit shows up as an enable that stays on.

// File: rtl/ucc_pkg.sv
package ucc_pkg;

  localparam int OPW = 7;
  localparam int F3W = 3;
  localparam int F7W = 7;
  localparam int RDW = 5;

  localparam logic [OPW-1:0] OP_RR  = 7'b0110011;
  localparam logic [OPW-1:0] OP_IAR = 7'b0010011;
  localparam logic [OPW-1:0] OP_LD  = 7'b0000011;
  localparam logic [OPW-1:0] OP_ST  = 7'b0100011;
  localparam logic [OPW-1:0] OP_BR  = 7'b1100011;

  localparam logic [F7W-1:0] F7_BASE = 7'b0000000;
  localparam logic [F7W-1:0] F7_ALT  = 7'b0100000;

  // Stages that own a gated functional unit
  localparam int NSTG   = 3;
  localparam int STG_EX = 0;
  localparam int STG_MEM = 1;
  localparam int STG_WB = 2;

  // Functional-unit slots in the gate-cell vector
  localparam int NUNIT  = 3;
  localparam int U_ALU  = 0;
  localparam int U_DMEM = 1;
  localparam int U_RFW  = 2;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_RR,
    CLS_IAR,
    CLS_LD,
    CLS_ST,
    CLS_BR
  } icls_e;

  function automatic logic cls_uses_alu(icls_e c);
    return (c == CLS_RR) || (c == CLS_IAR) || (c == CLS_BR);
  endfunction

  function automatic logic cls_uses_dmem(icls_e c);
    return (c == CLS_LD) || (c == CLS_ST);
  endfunction

  function automatic logic cls_writes_reg(icls_e c);
    return (c == CLS_RR) || (c == CLS_IAR) || (c == CLS_LD);
  endfunction

endpackage

// File: rtl/ucc_decode.sv
module ucc_decode
  import ucc_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  input  logic [F3W-1:0] f3_i,
  input  logic [F7W-1:0] f7_i,
  output icls_e          cls_o
);

  logic f7_base, f7_alt;

  assign f7_base = (f7_i == F7_BASE);
  assign f7_alt  = (f7_i == F7_ALT);

  always_comb begin
    cls_o = CLS_NONE;
    unique case (op_i)
      OP_RR: begin
        // alternate funct7 only for sub and sra
        if (f7_base || (f7_alt && (f3_i == 3'b000 || f3_i == 3'b101)))
          cls_o = CLS_RR;
      end
      OP_IAR: begin
        unique case (f3_i)
          3'b001:  if (f7_base) cls_o = CLS_IAR;
          3'b101:  if (f7_base || f7_alt) cls_o = CLS_IAR;
          default: cls_o = CLS_IAR;
        endcase
      end
      OP_LD: begin
        unique case (f3_i)
          3'b000, 3'b001, 3'b010, 3'b100, 3'b101: cls_o = CLS_LD;
          default: cls_o = CLS_NONE;
        endcase
      end
      OP_ST: begin
        if (f3_i <= 3'b010) cls_o = CLS_ST;
      end
      OP_BR: begin
        if (f3_i != 3'b010 && f3_i != 3'b011) cls_o = CLS_BR;
      end
      default: cls_o = CLS_NONE;
    endcase
  end

endmodule

// File: rtl/ucc_gate_cell.sv
module ucc_gate_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic en_o,
  output logic gclk_o
);

  // Captured while the clock falls, so the AND input is steady for the whole high phase
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_o <= 1'b0;
    else        en_o <= req_i;
  end

  assign gclk_o = clk & en_o;

endmodule

// File: rtl/unit_clk_ctrl.sv
module unit_clk_ctrl
  import ucc_pkg::*;
#(
  parameter int NPR = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [6:0]      ex_op_i,
  input  logic [2:0]      ex_f3_i,
  input  logic [6:0]      ex_f7_i,
  input  logic            ex_valid_i,
  input  logic [6:0]      mem_op_i,
  input  logic [2:0]      mem_f3_i,
  input  logic            mem_valid_i,
  input  logic [6:0]      wb_op_i,
  input  logic [2:0]      wb_f3_i,
  input  logic [6:0]      wb_f7_i,
  input  logic [4:0]      wb_rd_i,
  input  logic            wb_valid_i,
  input  logic [2:0]      flush_i,
  input  logic [NPR-1:0]  hold_i,
  input  logic            idle_i,
  output logic            alu_en_o,
  output logic            dmem_en_o,
  output logic            rfw_en_o,
  output logic [NPR-1:0]  preg_en_o,
  output logic            alu_gclk_o,
  output logic            dmem_gclk_o,
  output logic            rfw_gclk_o,
  output logic [NPR-1:0]  preg_gclk_o
);

  localparam int NCELL    = NUNIT + NPR;
  localparam int HOLD_EX  = NPR - 2;  // register written by execute
  localparam int HOLD_MEM = NPR - 1;  // register written by memory

  logic [OPW-1:0] stg_op    [NSTG];
  logic [F3W-1:0] stg_f3    [NSTG];
  logic [F7W-1:0] stg_f7    [NSTG];
  logic           stg_valid [NSTG];
  icls_e          stg_cls   [NSTG];
  logic [NSTG-1:0] stg_live;

  assign stg_op[STG_EX]     = ex_op_i;
  assign stg_f3[STG_EX]     = ex_f3_i;
  assign stg_f7[STG_EX]     = ex_f7_i;
  assign stg_valid[STG_EX]  = ex_valid_i;
  assign stg_op[STG_MEM]    = mem_op_i;
  assign stg_f3[STG_MEM]    = mem_f3_i;
  assign stg_f7[STG_MEM]    = '0;       // loads and stores carry no funct7
  assign stg_valid[STG_MEM] = mem_valid_i;
  assign stg_op[STG_WB]     = wb_op_i;
  assign stg_f3[STG_WB]     = wb_f3_i;
  assign stg_f7[STG_WB]     = wb_f7_i;
  assign stg_valid[STG_WB]  = wb_valid_i;

  generate
    for (genvar s = 0; s < NSTG; s++) begin : g_stage
      ucc_decode u_dec (
        .op_i  (stg_op[s]),
        .f3_i  (stg_f3[s]),
        .f7_i  (stg_f7[s]),
        .cls_o (stg_cls[s])
      );
      // a flushed or empty stage is a bubble
      assign stg_live[s] = stg_valid[s] && !flush_i[s] && !idle_i;
    end
  endgenerate

  logic [NCELL-1:0] req, en, gclk;

  always_comb begin
    req = '0;
    req[U_ALU]  = stg_live[STG_EX] && cls_uses_alu(stg_cls[STG_EX]) && !hold_i[HOLD_EX];
    req[U_DMEM] = stg_live[STG_MEM] && cls_uses_dmem(stg_cls[STG_MEM]) && !hold_i[HOLD_MEM];
    req[U_RFW]  = stg_live[STG_WB] && cls_writes_reg(stg_cls[STG_WB]) && (wb_rd_i != '0);
    for (int k = 0; k < NPR; k++) begin
      req[NUNIT+k] = !idle_i && !hold_i[k];
    end
  end

  generate
    for (genvar c = 0; c < NCELL; c++) begin : g_cell
      ucc_gate_cell u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req[c]),
        .en_o   (en[c]),
        .gclk_o (gclk[c])
      );
    end
  endgenerate

  assign alu_en_o    = en[U_ALU];
  assign dmem_en_o   = en[U_DMEM];
  assign rfw_en_o    = en[U_RFW];
  assign preg_en_o   = en[NCELL-1:NUNIT];
  assign alu_gclk_o  = gclk[U_ALU];
  assign dmem_gclk_o = gclk[U_DMEM];
  assign rfw_gclk_o  = gclk[U_RFW];
  assign preg_gclk_o = gclk[NCELL-1:NUNIT];

endmodule

// File: rtl/ucc_checker.sv
module ucc_checker
  import ucc_pkg::*;
#(
  parameter int NPR = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [6:0]     ex_op_i,
  input logic           ex_valid_i,
  input logic [6:0]     mem_op_i,
  input logic           mem_valid_i,
  input logic [6:0]     wb_op_i,
  input logic [4:0]     wb_rd_i,
  input logic           wb_valid_i,
  input logic [2:0]     flush_i,
  input logic [NPR-1:0] hold_i,
  input logic           idle_i,
  input logic           alu_en_o,
  input logic           dmem_en_o,
  input logic           rfw_en_o,
  input logic [NPR-1:0] preg_en_o,
  input logic           alu_gclk_o,
  input logic           dmem_gclk_o,
  input logic           rfw_gclk_o,
  input logic [NPR-1:0] preg_gclk_o
);

  logic [NPR+2:0] en_bus, gclk_bus;
  assign en_bus   = {preg_en_o, rfw_en_o, dmem_en_o, alu_en_o};
  assign gclk_bus = {preg_gclk_o, rfw_gclk_o, dmem_gclk_o, alu_gclk_o};

  a_r2_alu_class: assert property (@(posedge clk) disable iff (!rst_n)
    alu_en_o |-> ex_valid_i && (ex_op_i == OP_RR || ex_op_i == OP_IAR || ex_op_i == OP_BR));

  a_r3_dmem_class: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_en_o |-> mem_valid_i && (mem_op_i == OP_LD || mem_op_i == OP_ST));

  a_r4_rfw_class: assert property (@(posedge clk) disable iff (!rst_n)
    rfw_en_o |-> wb_valid_i && (wb_rd_i != 5'd0) &&
                 (wb_op_i == OP_RR || wb_op_i == OP_IAR || wb_op_i == OP_LD));

  a_r6_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i & preg_en_o) == '0);

  a_r7_hold_units: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i[NPR-2] |-> !alu_en_o) and (hold_i[NPR-1] |-> !dmem_en_o));

  a_r8_flush_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    ((flush_i[0] |-> !alu_en_o) and (flush_i[1] |-> !dmem_en_o) and (flush_i[2] |-> !rfw_en_o)));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    idle_i |-> (en_bus == '0));

  // R9: an enable may only move while the free clock is low
  always @(en_bus) begin
    if (rst_n) a_r9_change_low: assert (!clk);
  end

  // R10: no gated pulse outside the high phase
  always @(gclk_bus) begin
    if (gclk_bus != '0) a_r10_pulse_in_high: assert (clk);
  end

  // R11: reset keeps everything off
  always @(posedge clk) begin
    if (!rst_n) a_r11_reset_clear: assert (en_bus == '0 && gclk_bus == '0);
  end

endmodule

bind unit_clk_ctrl ucc_checker #(.NPR(NPR)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ex_op_i     (ex_op_i),
  .ex_valid_i  (ex_valid_i),
  .mem_op_i    (mem_op_i),
  .mem_valid_i (mem_valid_i),
  .wb_op_i     (wb_op_i),
  .wb_rd_i     (wb_rd_i),
  .wb_valid_i  (wb_valid_i),
  .flush_i     (flush_i),
  .hold_i      (hold_i),
  .idle_i      (idle_i),
  .alu_en_o    (alu_en_o),
  .dmem_en_o   (dmem_en_o),
  .rfw_en_o    (rfw_en_o),
  .preg_en_o   (preg_en_o),
  .alu_gclk_o  (alu_gclk_o),
  .dmem_gclk_o (dmem_gclk_o),
  .rfw_gclk_o  (rfw_gclk_o),
  .preg_gclk_o (preg_gclk_o)
);

// File: tb/sim_unit_clk_ctrl.sv
`timescale 1ns/1ps
module sim_unit_clk_ctrl;

  localparam int NPR = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [31:0] ex_w, mem_w, wb_w;
  logic ex_v, mem_v, wb_v;
  logic [2:0] flush;
  logic [NPR-1:0] hold;
  logic idle;
  logic alu_en, dmem_en, rfw_en, alu_g, dmem_g, rfw_g;
  logic [NPR-1:0] preg_en, preg_g;

  unit_clk_ctrl #(.NPR(NPR)) u0 (
    .clk(clk), .rst_n(rst_n),
    .ex_op_i(ex_w[6:0]), .ex_f3_i(ex_w[14:12]), .ex_f7_i(ex_w[31:25]), .ex_valid_i(ex_v),
    .mem_op_i(mem_w[6:0]), .mem_f3_i(mem_w[14:12]), .mem_valid_i(mem_v),
    .wb_op_i(wb_w[6:0]), .wb_f3_i(wb_w[14:12]), .wb_f7_i(wb_w[31:25]), .wb_rd_i(wb_w[11:7]),
    .wb_valid_i(wb_v), .flush_i(flush), .hold_i(hold), .idle_i(idle),
    .alu_en_o(alu_en), .dmem_en_o(dmem_en), .rfw_en_o(rfw_en), .preg_en_o(preg_en),
    .alu_gclk_o(alu_g), .dmem_gclk_o(dmem_g), .rfw_gclk_o(rfw_g), .preg_gclk_o(preg_g)
  );

  // Encodings (R1)
  localparam logic [31:0] I_ADD   = 32'h003100B3; // add x1
  localparam logic [31:0] I_SUB   = 32'h403102B3;
  localparam logic [31:0] I_BADR  = 32'h403112B3; // sll with funct7 0100000
  localparam logic [31:0] I_MUL   = 32'h023102B3; // funct7 0000001
  localparam logic [31:0] I_ADDI  = 32'h00500313; // addi x6
  localparam logic [31:0] I_SRAI  = 32'h4023D393; // srai x7
  localparam logic [31:0] I_BADSL = 32'h40239393; // slli with funct7 0100000
  localparam logic [31:0] I_LW    = 32'h00012403; // lw x8
  localparam logic [31:0] I_LB0   = 32'h00010003; // lb x0
  localparam logic [31:0] I_BADLD = 32'h00013403; // funct3 011
  localparam logic [31:0] I_SW    = 32'h00312223;
  localparam logic [31:0] I_BADST = 32'h00313223; // funct3 011
  localparam logic [31:0] I_BEQ   = 32'h00208463;
  localparam logic [31:0] I_BADBR = 32'h0020A463; // funct3 010
  localparam logic [31:0] I_LUI   = 32'h000010B7;
  localparam logic [31:0] I_NOP   = 32'h00000013; // addi x0
  localparam logic [31:0] I_ZERO  = 32'h00000000;

  typedef struct packed {
    logic [31:0] ex;  logic exv;
    logic [31:0] mem; logic memv;
    logic [31:0] wb;  logic wbv;
    logic [2:0]  fl;
    logic [3:0]  hd;
    logic        idl;
    logic [2:0]  eu;   // {alu, dmem, rfw}
    logic [3:0]  ep;   // pipeline registers
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{I_ADD,  1'b1, I_LW,    1'b1, I_ADD,   1'b1, 3'b000, 4'b0000, 1'b0, 3'b111, 4'b1111}, // R2 R3 R4
    '{I_SUB,  1'b1, I_SW,    1'b1, I_LW,    1'b1, 3'b000, 4'b0000, 1'b0, 3'b111, 4'b1111},
    '{I_ADDI, 1'b1, I_ADD,   1'b1, I_SW,    1'b1, 3'b000, 4'b0000, 1'b0, 3'b100, 4'b1111}, // R4 store
    '{I_SRAI, 1'b1, I_LB0,   1'b1, I_BEQ,   1'b1, 3'b000, 4'b0000, 1'b0, 3'b110, 4'b1111}, // R4 branch
    '{I_BEQ,  1'b1, I_BADLD, 1'b1, I_LB0,   1'b1, 3'b000, 4'b0000, 1'b0, 3'b100, 4'b1111}, // R4 x0, R5
    '{I_LW,   1'b1, I_BEQ,   1'b1, I_ADDI,  1'b1, 3'b000, 4'b0000, 1'b0, 3'b001, 4'b1111},
    '{I_SW,   1'b1, I_SW,    1'b1, I_NOP,   1'b1, 3'b000, 4'b0000, 1'b0, 3'b010, 4'b1111},
    '{I_BADR, 1'b1, I_BADST, 1'b1, I_MUL,   1'b1, 3'b000, 4'b0000, 1'b0, 3'b000, 4'b1111}, // R5
    '{I_MUL,  1'b1, I_LUI,   1'b1, I_BADSL, 1'b1, 3'b000, 4'b0000, 1'b0, 3'b000, 4'b1111}, // R5
    '{I_BADSL,1'b1, I_ZERO,  1'b1, I_BADBR, 1'b1, 3'b000, 4'b0000, 1'b0, 3'b000, 4'b1111}, // R5
    '{I_BADBR,1'b1, I_LW,    1'b1, I_SRAI,  1'b1, 3'b000, 4'b0000, 1'b0, 3'b011, 4'b1111},
    '{I_LUI,  1'b1, I_LW,    1'b1, I_LUI,   1'b1, 3'b000, 4'b0000, 1'b0, 3'b010, 4'b1111}, // R5
    '{I_ADD,  1'b0, I_LW,    1'b0, I_ADD,   1'b0, 3'b000, 4'b0000, 1'b0, 3'b000, 4'b1111}, // R11 bubbles
    '{I_ADD,  1'b1, I_LW,    1'b1, I_ADD,   1'b1, 3'b001, 4'b0000, 1'b0, 3'b011, 4'b1111}, // R8
    '{I_ADD,  1'b1, I_LW,    1'b1, I_ADD,   1'b1, 3'b110, 4'b0000, 1'b0, 3'b100, 4'b1111}, // R8
    '{I_ADD,  1'b1, I_LW,    1'b1, I_ADD,   1'b1, 3'b000, 4'b0100, 1'b0, 3'b011, 4'b1011}, // R7 R6
    '{I_ADD,  1'b1, I_LW,    1'b1, I_ADD,   1'b1, 3'b000, 4'b1000, 1'b0, 3'b101, 4'b0111}, // R7 R6
    '{I_ADD,  1'b1, I_LW,    1'b1, I_ADD,   1'b1, 3'b000, 4'b0011, 1'b0, 3'b111, 4'b1100}, // R6
    '{I_ADD,  1'b1, I_LW,    1'b1, I_ADD,   1'b1, 3'b000, 4'b0000, 1'b1, 3'b000, 4'b0000}, // R12
    '{I_ADD,  1'b1, I_LW,    1'b1, I_ADD,   1'b1, 3'b000, 4'b0000, 1'b0, 3'b111, 4'b1111}
  };

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [2:0] prev_u;
  logic [3:0] prev_p;

  task automatic chk(input string req, input int idx, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s step %0d actual=%h expected=%h", req, idx, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic drive(input vec_t v);
    ex_w = v.ex; ex_v = v.exv; mem_w = v.mem; mem_v = v.memv;
    wb_w = v.wb; wb_v = v.wbv; flush = v.fl; hold = v.hd; idle = v.idl;
  endtask

  // called at posedge + 1 ns; returns at the next posedge + 1 ns
  task automatic step(input vec_t v, input int idx);
    drive(v);
    #0.5;  // still in the high phase: old enables must remain (R9)
    chk("R9", idx, {29'd0, alu_en, dmem_en, rfw_en}, {29'd0, prev_u});
    chk("R9", idx, {28'd0, preg_en}, {28'd0, prev_p});
    @(negedge clk); #1;
    chk("R2", idx, {31'd0, alu_en},  {31'd0, v.eu[2]});
    chk("R3", idx, {31'd0, dmem_en}, {31'd0, v.eu[1]});
    chk("R4", idx, {31'd0, rfw_en},  {31'd0, v.eu[0]});
    chk("R6", idx, {28'd0, preg_en}, {28'd0, v.ep});
    chk("R10", idx, {28'd0, alu_g, dmem_g, rfw_g, |preg_g}, 32'd0);
    @(posedge clk); #0.5;
    chk("R10", idx, {25'd0, alu_g, dmem_g, rfw_g, preg_g}, {25'd0, v.eu, v.ep});
    #0.5;
    prev_u = v.eu; prev_p = v.ep;
  endtask

  initial begin
    rst_n = 1'b0;
    prev_u = '0; prev_p = '0;
    drive(VEC[0]);
    repeat (3) @(posedge clk);
    #0.5;
    // R11: requests present but reset holds everything off
    chk("R11", -1, {25'd0, alu_en, dmem_en, rfw_en, preg_en}, 32'd0);
    chk("R11", -1, {25'd0, alu_g, dmem_g, rfw_g, preg_g}, 32'd0);
    #0.5;
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) step(VEC[i], i);

    // R11: asynchronous reset mid-run clears enables at once
    rst_n = 1'b0;
    #0.2;
    chk("R11", 100, {25'd0, alu_en, dmem_en, rfw_en, preg_en}, 32'd0);
    chk("R11", 100, {25'd0, alu_g, dmem_g, rfw_g, preg_g}, 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    prev_u = '0; prev_p = '0;
    step(VEC[0], 101);

    // R9: a request lasting one cycle yields exactly one gated pulse
    step(VEC[18], 102);
    step(VEC[5], 103);
    step(VEC[18], 104);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

endmodule